// File: doc/BRIEF.md
# Packed SIMD Integer ALU

This block is a 128-bit packed integer execution unit for a vector-capable integer pipeline. Each issued operation carries two 128-bit source operands, an opcode and a lane-size code that splits the word into sixteen 8-bit, eight 16-bit or four 32-bit lanes. Every lane is computed on its own, with no carry or borrow crossing a lane boundary. The available operations are wrapping add and subtract, signed minimum and maximum, three shifts, four bitwise functions and a per-lane leading-zero count. A funnel extract also treats the two sources as one 256-bit value and returns a 128-bit window of it at a byte offset.

The datapath is two identical 64-bit halves. Each half holds every lane width and selects the one that the lane-size code asks for. The funnel extract sits beside the two halves because its window crosses the half boundary. The result is registered. An operation presented with `in_valid` high appears on `result` with `out_valid` high on the next clock edge. The block accepts one operation per cycle.

Top module: `simd_alu`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid` is 0 and `result` is all zeros.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `result` changes only after an accepted operation and holds its value through idle cycles.
- R3: Lane code 0 selects 8-bit lanes, 1 selects 16-bit lanes and 2 selects 32-bit lanes. Opcode 0 (add) and opcode 1 (subtract, a minus b) wrap modulo the lane width, with no carry or borrow between lanes.
- R4: Opcode 2 returns the smaller and opcode 3 the larger lane value, comparing lanes as signed two's-complement numbers.
- R5: Opcodes 4, 5 and 6 shift each lane of a left-logical, right-logical and right-arithmetic. The amount is the corresponding lane of b taken modulo the lane width.
- R6: Opcodes 7, 8, 9 and 10 return a AND b, a OR b, a XOR b and NOT(a OR b) over all 128 bits.
- R7: Opcode 11 returns in each lane the count of leading zeros of that lane of a. An all-zero lane yields the lane width.
- R8: Opcode 12 forms the 256-bit value {b, a}, shifts it right by 8 times `window_bytes` bits and returns the low 128 bits. An offset of 0 yields a, 16 yields b, and any offset above 16 acts as 16.
- R9: Opcodes 13, 14 and 15 produce an all-zero result.
- R10: Lane code 3 behaves exactly like lane code 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation presented this cycle |
| op | input | 4 | Opcode |
| lane_sel | input | 2 | Lane-size code |
| src_a | input | 128 | First source operand |
| src_b | input | 128 | Second source operand, which also supplies the shift amounts |
| window_bytes | input | 5 | Funnel extract offset in bytes |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Registered result |

## Verification
Each lane is computed in one stage and registered, so a fault in the lane selection or in the shift-amount slicing shows on `result` in the cycle after the operation. A stray carry across a lane boundary shows there too, as a wrong bit in the neighbouring lane. Such faults are exposed most quickly by operands at the lane edges, such as 8'hFF plus 1, 0x80 against 0x7F, and shift amounts of a full lane width or more. A wrong valid register shows as `out_valid` high in an idle cycle, or as `result` moving during one. A miswired half shows as a wrong upper or lower 64 bits in the very next result.

// File: rtl/simd_pkg.sv
package simd_pkg;
    localparam int DATA_W = 128;
    localparam int HALF_W = DATA_W / 2;
    localparam int NUM_HALVES = DATA_W / HALF_W;
    localparam int WIN_W = 5;
    localparam int MAX_WIN_BYTES = DATA_W / 8;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0, OP_SUB = 4'd1, OP_MIN = 4'd2, OP_MAX = 4'd3,
        OP_SLL = 4'd4, OP_SRL = 4'd5, OP_SRA = 4'd6,
        OP_AND = 4'd7, OP_OR = 4'd8, OP_XOR = 4'd9, OP_NOR = 4'd10,
        OP_CLZ = 4'd11, OP_FUNNEL = 4'd12,
        OP_RSV13 = 4'd13, OP_RSV14 = 4'd14, OP_RSV15 = 4'd15
    } simd_op_e;

    typedef enum logic [1:0] {
        LANE_8 = 2'd0, LANE_16 = 2'd1, LANE_32 = 2'd2, LANE_32B = 2'd3
    } lane_size_e;

    typedef struct packed {
        simd_op_e         op;
        lane_size_e       lsz;
        logic [WIN_W-1:0] win;
    } simd_ctrl_t;

    function automatic logic [WIN_W-1:0] clamp_window(input logic [WIN_W-1:0] w);
        return (w > WIN_W'(MAX_WIN_BYTES)) ? WIN_W'(MAX_WIN_BYTES) : w;
    endfunction
endpackage

// File: rtl/simd_lane.sv
module simd_lane
    import simd_pkg::*;
#(
    parameter int W = 8
) (
    input  simd_op_e       op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   y
);
    localparam int SH_W = $clog2(W);

    logic [SH_W-1:0] sh;
    int              lz;

    assign sh = b[SH_W-1:0];

    always_comb begin
        lz = W;
        for (int k = 0; k < W; k++) begin
            if (a[k]) lz = W - 1 - k;
        end
    end

    always_comb begin
        unique case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_MIN:  y = ($signed(a) < $signed(b)) ? a : b;
            OP_MAX:  y = ($signed(a) < $signed(b)) ? b : a;
            OP_SLL:  y = a << sh;
            OP_SRL:  y = a >> sh;
            OP_SRA:  y = $signed(a) >>> sh;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_NOR:  y = ~(a | b);
            OP_CLZ:  y = W'(lz);
            default: y = '0;
        endcase
    end

    always_comb begin
        if (op == OP_CLZ) begin
            p_clz_bound_r7: assert (y <= W);
        end
        if (op == OP_MIN) begin
            p_min_pick_r4: assert (y == a || y == b);
        end
    end
endmodule

// File: rtl/simd_half.sv
module simd_half
    import simd_pkg::*;
#(
    parameter int HW = HALF_W
) (
    input  simd_op_e         op,
    input  lane_size_e       lsz,
    input  logic [HW-1:0]    a,
    input  logic [HW-1:0]    b,
    output logic [HW-1:0]    y
);
    localparam int NUM_SIZES = 3;

    logic [HW-1:0] by_size [NUM_SIZES];

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        localparam int LW = 8 << s;
        localparam int NL = HW / LW;
        for (genvar l = 0; l < NL; l++) begin : g_lane
            simd_lane #(.W(LW)) i_lane (
                .op (op),
                .a  (a[l*LW +: LW]),
                .b  (b[l*LW +: LW]),
                .y  (by_size[s][l*LW +: LW])
            );
        end
    end

    always_comb begin
        unique case (lsz)
            LANE_8:  y = by_size[0];
            LANE_16: y = by_size[1];
            default: y = by_size[2];
        endcase
    end
endmodule

// File: rtl/simd_funnel.sv
module simd_funnel
    import simd_pkg::*;
(
    input  logic [DATA_W-1:0] lo,
    input  logic [DATA_W-1:0] hi,
    input  logic [WIN_W-1:0]  win,
    output logic [DATA_W-1:0] y
);
    localparam int CAT_W = 2 * DATA_W;
    localparam int IDX_W = $clog2(CAT_W);

    logic [CAT_W-1:0] cat;
    logic [WIN_W-1:0] eff;
    logic [IDX_W-1:0] bit_off;

    assign cat     = {hi, lo};
    assign eff     = clamp_window(win);
    assign bit_off = IDX_W'({eff, 3'b000});
    assign y       = cat[bit_off +: DATA_W];

    always_comb begin
        p_window_range_r8: assert (bit_off <= IDX_W'(DATA_W));
    end
endmodule

// File: rtl/simd_alu.sv
module simd_alu
    import simd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [3:0]          op,
    input  logic [1:0]          lane_sel,
    input  logic [DATA_W-1:0]   src_a,
    input  logic [DATA_W-1:0]   src_b,
    input  logic [WIN_W-1:0]    window_bytes,
    output logic                out_valid,
    output logic [DATA_W-1:0]   result
);
    simd_ctrl_t        ctrl;
    logic [DATA_W-1:0] lane_res;
    logic [DATA_W-1:0] fun_res;
    logic [DATA_W-1:0] next_res;

    assign ctrl.op  = simd_op_e'(op);
    assign ctrl.lsz = lane_size_e'(lane_sel);
    assign ctrl.win = window_bytes;

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        simd_half #(.HW(HALF_W)) i_half (
            .op  (ctrl.op),
            .lsz (ctrl.lsz),
            .a   (src_a[h*HALF_W +: HALF_W]),
            .b   (src_b[h*HALF_W +: HALF_W]),
            .y   (lane_res[h*HALF_W +: HALF_W])
        );
    end

    simd_funnel i_funnel (
        .lo  (src_a),
        .hi  (src_b),
        .win (ctrl.win),
        .y   (fun_res)
    );

    assign next_res = (ctrl.op == OP_FUNNEL) ? fun_res : lane_res;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) result <= next_res;
        end
    end

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (!out_valid && result == '0));
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));
    p_logic_and_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 4'd7) |=> (result == $past(src_a & src_b)));
    p_funnel_low_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 4'd12 && window_bytes == '0) |=> (result == $past(src_a)));
    p_funnel_high_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 4'd12 && window_bytes >= 5'd16) |=> (result == $past(src_b)));
    p_reserved_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op >= 4'd13) |=> (result == '0));
endmodule

// File: tb/test_simd_alu.sv
module test_simd_alu;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [3:0]   op = '0;
    logic [1:0]   lane_sel = '0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [4:0]   window_bytes = '0;
    logic         out_valid;
    logic [127:0] result;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    simd_alu i_simd_alu (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .lane_sel(lane_sel),
        .src_a(src_a), .src_b(src_b), .window_bytes(window_bytes),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [127:0] model(input int o, input int ls, input logic [127:0] a,
                                           input logic [127:0] b, input int wb);
        logic [127:0] res = '0;
        logic [255:0] cat;
        int w = (ls == 0) ? 8 : (ls == 1) ? 16 : 32;
        longint mask = (64'sd1 <<< w) - 1;
        if (o == 12) begin
            cat = {b, a} >> ((wb > 16 ? 16 : wb) * 8);
            return cat[127:0];
        end
        if (o == 7) return a & b;
        if (o == 8) return a | b;
        if (o == 9) return a ^ b;
        if (o == 10) return ~(a | b);
        if (o > 12) return '0;
        for (int i = 0; i < 128 / w; i++) begin
            longint x = longint'((a >> (i * w)) & 128'(mask));
            longint y = longint'((b >> (i * w)) & 128'(mask));
            longint sx = (x >= (64'sd1 <<< (w - 1))) ? x - (64'sd1 <<< w) : x;
            longint sy = (y >= (64'sd1 <<< (w - 1))) ? y - (64'sd1 <<< w) : y;
            int s = int'(y % longint'(w));
            longint r = 0;
            case (o)
                0: r = x + y;
                1: r = x - y;
                2: r = (sx < sy) ? x : y;
                3: r = (sx < sy) ? y : x;
                4: r = x <<< s;
                5: r = x >>> s;
                6: r = sx >>> s;
                default: begin
                    r = w;
                    for (int k = 0; k < w; k++) if (x[k]) r = w - 1 - k;
                end
            endcase
            res = res | (128'(r & mask) << (i * w));
        end
        return res;
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input string tag, input int o, input int ls, input logic [127:0] a,
                         input logic [127:0] b, input int wb);
        @(negedge clk);
        in_valid = 1'b1; op = 4'(o); lane_sel = 2'(ls);
        src_a = a; src_b = b; window_bytes = 5'(wb);
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid"}, 128'(out_valid), 128'(1));
        check(tag, result, model(o, ls, a, b, wb));
    endtask

    initial begin
        #(20ns * 200000);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [127:0] held;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R1 reset valid", 128'(out_valid), 128'(0));
        check("R1 reset result", result, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset valid", 128'(out_valid), 128'(0));
        check("R1 after reset result", result, '0);

        issue("R3 add 8-bit no carry", 0, 0, {16{8'hFF}}, {16{8'h01}}, 0);
        issue("R3 sub 16-bit wrap", 1, 1, '0, {8{16'h0001}}, 0);
        issue("R3 add 32-bit", 0, 2, {4{32'hFFFF_FFFF}}, {4{32'h0000_0002}}, 0);
        issue("R4 min signed 8", 2, 0, {16{8'h80}}, {16{8'h7F}}, 0);
        issue("R4 max signed 16", 3, 1, {8{16'h8000}}, {8{16'h7FFF}}, 0);
        issue("R5 sll 8 amount 9", 4, 0, {16{8'h81}}, {16{8'h09}}, 0);
        issue("R5 sra 32", 6, 2, {4{32'h8000_0000}}, {4{32'd35}}, 0);
        issue("R5 srl 16", 5, 1, {8{16'h8000}}, {8{16'd15}}, 0);
        issue("R6 nor", 10, 0, {4{32'h0F0F_1234}}, {4{32'hF000_0001}}, 0);
        issue("R7 clz zero lanes 8", 11, 0, '0, '0, 0);
        issue("R7 clz 32 mixed", 11, 2, {32'h0, 32'h1, 32'h8000_0000, 32'h0001_0000}, '0, 0);
        issue("R8 funnel offset 0", 12, 0, {4{32'hA5A5_0001}}, {4{32'h5A5A_0002}}, 0);
        issue("R8 funnel offset 16", 12, 0, {4{32'hA5A5_0001}}, {4{32'h5A5A_0002}}, 16);
        issue("R8 funnel offset 21", 12, 0, {4{32'hA5A5_0001}}, {4{32'h5A5A_0002}}, 21);
        issue("R8 funnel offset 5", 12, 1, {4{32'h1234_5678}}, {4{32'h9ABC_DEF0}}, 5);
        issue("R9 reserved op", 13, 0, {4{32'hFFFF_FFFF}}, {4{32'h1234_5678}}, 0);
        issue("R10 lane code 3 add", 0, 3, {4{32'h0000_FFFF}}, {4{32'h0000_0001}}, 0);

        held = result;
        @(negedge clk);
        check("R2 idle valid low", 128'(out_valid), 128'(0));
        check("R2 idle result held", result, held);
        src_a = '1; src_b = '1; op = 4'd0;
        @(negedge clk);
        check("R2 inputs ignored while idle", result, held);

        for (int n = 0; n < 400; n++) begin
            logic [127:0] ra = {$urandom, $urandom, $urandom, $urandom};
            logic [127:0] rb = {$urandom, $urandom, $urandom, $urandom};
            int ro = int'($urandom % 16);
            int rl = int'($urandom % 4);
            int rw = int'($urandom % 32);
            string t;
            case (ro)
                0, 1: t = "R3 random";
                2, 3: t = "R4 random";
                4, 5, 6: t = "R5 random";
                7, 8, 9, 10: t = "R6 random";
                11: t = "R7 random";
                12: t = "R8 random";
                default: t = "R9 random";
            endcase
            if (rl == 3) t = "R10 random";
            issue(t, ro, rl, ra, rb, rw);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule